// File: doc/BRIEF.md
# Self-Programming Flash Section Arbiter

This block governs page erase and page write operations that the running program issues against its own program flash. The flash address space is cut two ways. A fixed boundary separates a lower region that stays readable while it is being programmed from an upper region whose programming stops the CPU. A movable boundary, chosen by a 2-bit configuration input, marks off a boot section at the top of the space. The boot section is always contained in the upper, non-readable-while-programming region.

A program-store request is presented on a valid/ready handshake. It carries an erase/write flag and a target word address, and it is sampled together with the current program-counter address. `req_ready` is high exactly when no operation is running, so a request that arrives mid-operation is held off by back-pressure rather than queued. A handshake whose program counter lies outside the boot section is consumed and dropped. A handshake from inside the boot section starts an operation of a fixed, per-kind length. If the target lies in the upper region, the CPU is halted for the whole operation. If the target lies in the lower region, the CPU keeps running and a sticky lower-region-busy flag is set. While that flag is set, instruction fetches into the lower region are replaced by a fill word and flagged as violations. The flag is cleared only by an explicit clear command issued while the block is idle.

Top module: `flash_selfprog_arb`

## Requirements
- R1: A handshake (`req_valid` and `req_ready` high at a clock edge) starts an operation only if `pc_addr` is at or above the boot start. Otherwise the request is dropped, and `busy`, `cpu_halt` and `rww_busy` keep their values.
- R2: The boot start is 4096 minus 128 shifted left by (3 − `boot_sz_cfg`). This gives 0xF80, 0xF00, 0xE00 and 0xC00 for configuration values 3, 2, 1 and 0. The boot start is never below the region boundary at 0xC00.
- R3: The target address of an accepted request is unrestricted and may lie inside the boot section itself.
- R4: `req_ready` equals the inverse of `busy`. `busy` rises in the cycle after acceptance and stays high for exactly ERASE_CYCLES (40) cycles when `req_erase` is 1, or exactly WRITE_CYCLES (24) cycles when it is 0. A request offered while `busy` is high starts nothing.
- R5: `prog_done` is high for exactly one cycle: the first cycle after `busy` falls.
- R6: When the target is at or above 0xC00, `cpu_halt` is high in exactly the cycles in which `busy` is high for that operation, and low otherwise.
- R7: When the target is below 0xC00, `cpu_halt` stays low and `rww_busy` becomes 1 in the cycle after acceptance. `rww_busy` stays 1 after the operation completes.
- R8: `rww_clr_cmd` sampled while `busy` is low clears `rww_busy` at that edge. Sampled while `busy` is high, it has no effect. If a lower-region operation is accepted at the same edge as a clear, the flag ends up set.
- R9: While `rww_busy` is 1, a `fetch_addr` below 0xC00 drives `fetch_viol` high and `fetch_rdata` to 0xFFFF. In every other case `fetch_viol` is low and `fetch_rdata` equals `flash_rdata`. Both outputs are combinational.
- R10: After reset, `busy`, `cpu_halt`, `rww_busy` and `prog_done` are 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boot_sz_cfg | input | 2 | Boot section size select |
| pc_addr | input | ADDR_W (12) | Address of the instruction issuing the request |
| req_valid | input | 1 | Program-store request offered |
| req_ready | output | 1 | Block can take a request |
| req_erase | input | 1 | 1 = page erase, 0 = page write |
| req_addr | input | ADDR_W (12) | Target word address |
| rww_clr_cmd | input | 1 | Command to clear the lower-region-busy flag |
| busy | output | 1 | Operation in progress |
| cpu_halt | output | 1 | CPU stall request |
| rww_busy | output | 1 | Sticky lower-region-busy flag |
| prog_done | output | 1 | One-cycle completion pulse |
| fetch_addr | input | ADDR_W (12) | CPU fetch address |
| flash_rdata | input | DATA_W (16) | Raw flash read word |
| fetch_rdata | output | DATA_W (16) | Word returned to the CPU |
| fetch_viol | output | 1 | Fetch hit the blocked region |

## Verification
Two things can meet in one cycle: the end of an operation and a clear command for the lower-region flag. The bench counts cycles from acceptance and raises the clear in the very last busy cycle. It expects the flag to survive that edge with `prog_done` rising. It then holds the clear into the done cycle and expects the flag to drop. A second collision puts a clear and a newly accepted lower-region request on the same edge, and the flag is judged set. A scoreboard independently checks every operation's busy length and halt cycles against what the driver pushed.

// File: rtl/flash_arb_pkg.sv
package flash_arb_pkg;
  typedef enum logic {
    OP_WRITE = 1'b0,
    OP_ERASE = 1'b1
  } prog_op_e;
endpackage

// File: rtl/sect_decode.sv
module sect_decode #(
  parameter int ADDR_W         = 12,
  parameter int NRWW_BASE      = 'hC00,
  parameter int BOOT_MIN_WORDS = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        boot_sz_cfg,
  input  logic [ADDR_W-1:0] pc_addr,
  input  logic [ADDR_W-1:0] tgt_addr,
  output logic              pc_in_boot,
  output logic              tgt_upper
);
  localparam int FLASH_WORDS = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] UPPER_AT = ADDR_W'(NRWW_BASE);

  logic [ADDR_W-1:0] start_tbl [4];
  logic [ADDR_W-1:0] boot_start;

  // One boundary per configuration code; code 0 is the largest section.
  for (genvar g = 0; g < 4; g++) begin : g_start
    assign start_tbl[g] = ADDR_W'(FLASH_WORDS - (BOOT_MIN_WORDS << (3 - g)));
  end

  assign boot_start = start_tbl[boot_sz_cfg];
  assign pc_in_boot = (pc_addr >= boot_start);
  assign tgt_upper  = (tgt_addr >= UPPER_AT);

  // R2: boot section never reaches below the region boundary
  assert_boot_in_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pc_in_boot |-> (pc_addr >= UPPER_AT));
endmodule

// File: rtl/prog_timer.sv
module prog_timer
  import flash_arb_pkg::*;
#(
  parameter int ERASE_CYCLES = 40,
  parameter int WRITE_CYCLES = 24
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  prog_op_e op,
  output logic     active,
  output logic     last,
  output logic     done
);
  localparam int MAX_CYCLES = (ERASE_CYCLES > WRITE_CYCLES) ? ERASE_CYCLES : WRITE_CYCLES;
  localparam int CNT_W      = $clog2(MAX_CYCLES + 1);
  localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYCLES - 1);
  localparam logic [CNT_W-1:0] WRITE_LOAD = CNT_W'(WRITE_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  assign last = active && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      done   <= 1'b0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= (op == OP_ERASE) ? ERASE_LOAD : WRITE_LOAD;
      done   <= 1'b0;
    end else if (last) begin
      active <= 1'b0;
      done   <= 1'b1;
    end else begin
      if (active) cnt <= cnt - 1'b1;
      done <= 1'b0;
    end
  end

  assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt < CNT_W'(MAX_CYCLES)));
  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> done);
  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !active);
endmodule

// File: rtl/fetch_guard.sv
module fetch_guard #(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 16,
  parameter int NRWW_BASE = 'hC00,
  parameter logic [DATA_W-1:0] FILL_WORD = '1
) (
  input  logic              lower_locked,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic [DATA_W-1:0] flash_rdata,
  output logic [DATA_W-1:0] fetch_rdata,
  output logic              fetch_viol
);
  localparam logic [ADDR_W-1:0] UPPER_AT = ADDR_W'(NRWW_BASE);

  always_comb begin
    fetch_viol  = lower_locked && (fetch_addr < UPPER_AT);
    fetch_rdata = fetch_viol ? FILL_WORD : flash_rdata;
  end
endmodule

// File: rtl/flash_selfprog_arb.sv
module flash_selfprog_arb
  import flash_arb_pkg::*;
#(
  parameter int ADDR_W         = 12,
  parameter int DATA_W         = 16,
  parameter int NRWW_BASE      = 'hC00,
  parameter int BOOT_MIN_WORDS = 128,
  parameter int ERASE_CYCLES   = 40,
  parameter int WRITE_CYCLES   = 24,
  parameter logic [DATA_W-1:0] FILL_WORD = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        boot_sz_cfg,
  input  logic [ADDR_W-1:0] pc_addr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_erase,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              rww_clr_cmd,
  output logic              busy,
  output logic              cpu_halt,
  output logic              rww_busy,
  output logic              prog_done,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic [DATA_W-1:0] flash_rdata,
  output logic [DATA_W-1:0] fetch_rdata,
  output logic              fetch_viol
);
  logic pc_in_boot, tgt_upper, accept, op_last;

  sect_decode #(
    .ADDR_W(ADDR_W), .NRWW_BASE(NRWW_BASE), .BOOT_MIN_WORDS(BOOT_MIN_WORDS)
  ) u_decode (
    .clk(clk), .rst_n(rst_n), .boot_sz_cfg(boot_sz_cfg), .pc_addr(pc_addr),
    .tgt_addr(req_addr), .pc_in_boot(pc_in_boot), .tgt_upper(tgt_upper)
  );

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready && pc_in_boot;

  prog_timer #(
    .ERASE_CYCLES(ERASE_CYCLES), .WRITE_CYCLES(WRITE_CYCLES)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .start(accept), .op(prog_op_e'(req_erase)),
    .active(busy), .last(op_last), .done(prog_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_halt <= 1'b0;
    end else if (accept) begin
      cpu_halt <= tgt_upper;
    end else if (op_last) begin
      cpu_halt <= 1'b0;
    end
  end

  // Lower-region flag: an accepted lower-region operation wins over a clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rww_busy <= 1'b0;
    end else if (accept && !tgt_upper) begin
      rww_busy <= 1'b1;
    end else if (rww_clr_cmd && !busy) begin
      rww_busy <= 1'b0;
    end
  end

  fetch_guard #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NRWW_BASE(NRWW_BASE), .FILL_WORD(FILL_WORD)
  ) u_guard (
    .lower_locked(rww_busy), .fetch_addr(fetch_addr), .flash_rdata(flash_rdata),
    .fetch_rdata(fetch_rdata), .fetch_viol(fetch_viol)
  );

  assert_app_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !pc_in_boot) |=> !busy);
  assert_boot_take_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && pc_in_boot) |=> busy);
  assert_start_needs_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));
  assert_halt_within_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_halt |-> busy);
  assert_lower_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rww_busy && (busy || !rww_clr_cmd)) |=> rww_busy);
  assert_clean_fetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rww_busy |-> !fetch_viol);
  assert_fill_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_viol |-> (fetch_rdata == FILL_WORD));
endmodule

// File: tb/tb_flash_selfprog_arb.sv
module tb_flash_selfprog_arb;
  localparam int ERASE_LEN = 40;
  localparam int WRITE_LEN = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  boot_sz_cfg = 2'd3;
  logic [11:0] pc_addr = '0, req_addr = '0, fetch_addr = '0;
  logic        req_valid = 1'b0, req_erase = 1'b0, rww_clr_cmd = 1'b0;
  logic [15:0] flash_rdata = 16'h1234;
  logic        req_ready, busy, cpu_halt, rww_busy, prog_done, fetch_viol;
  logic [15:0] fetch_rdata;

  typedef struct { int len; bit halt; } exp_t;
  exp_t sb_q[$];
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  flash_selfprog_arb dut (
    .clk(clk), .rst_n(rst_n), .boot_sz_cfg(boot_sz_cfg), .pc_addr(pc_addr),
    .req_valid(req_valid), .req_ready(req_ready), .req_erase(req_erase),
    .req_addr(req_addr), .rww_clr_cmd(rww_clr_cmd), .busy(busy),
    .cpu_halt(cpu_halt), .rww_busy(rww_busy), .prog_done(prog_done),
    .fetch_addr(fetch_addr), .flash_rdata(flash_rdata),
    .fetch_rdata(fetch_rdata), .fetch_viol(fetch_viol)
  );

  task automatic chk(string req, string what, longint act, longint expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic int boot_start_of(int cfg);
    return 4096 - (128 << (3 - cfg));
  endfunction

  // Driver: offer a request for one edge, predict acceptance and push it.
  task automatic send(int pc, int addr, bit erase);
    exp_t e;
    pc_addr = 12'(pc); req_addr = 12'(addr); req_erase = erase; req_valid = 1'b1;
    if (req_ready && pc >= boot_start_of(int'(boot_sz_cfg))) begin
      e.len = erase ? ERASE_LEN : WRITE_LEN;
      e.halt = (addr >= 'hC00);
      sb_q.push_back(e);
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (!prog_done) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // Monitor: measures every operation and compares with the scoreboard.
  initial begin
    int bcnt = 0, hcnt = 0;
    bit prev_done = 0;
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (busy) begin bcnt++; if (cpu_halt) hcnt++; end
        if (prog_done && prev_done) chk("R5", "done pulse width", 2, 1);
        if (prog_done && !prev_done) begin
          if (sb_q.size() == 0) chk("R4", "unexpected completion", 1, 0);
          else begin
            e = sb_q.pop_front();
            chk("R4", "busy length", bcnt, e.len);
            chk("R6", "halt cycles", hcnt, e.halt ? e.len : 0);
            chk("R5", "halt after done", cpu_halt, 0);
          end
          bcnt = 0; hcnt = 0;
        end
        prev_done = prog_done;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", "busy", busy, 0);
    chk("R10", "halt", cpu_halt, 0);
    chk("R10", "rww_busy", rww_busy, 0);
    chk("R10", "done", prog_done, 0);
    chk("R10", "ready", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: application-section request dropped
    send('h100, 'h010, 0);
    chk("R1", "busy after app request", busy, 0);
    chk("R1", "rww after app request", rww_busy, 0);
    // R2: one word below the smallest boot section
    send('hF7F, 'h010, 0);
    chk("R2", "busy below boot start", busy, 0);
    // R2/R7: exactly at boot start, lower-region write
    send('hF80, 'h010, 0);
    chk("R2", "busy at boot start", busy, 1);
    chk("R4", "ready while busy", req_ready, 0);
    chk("R7", "rww set", rww_busy, 1);
    chk("R7", "no halt for lower target", cpu_halt, 0);
    fetch_addr = 12'h020; #1;
    chk("R9", "viol lower fetch", fetch_viol, 1);
    chk("R9", "fill word", fetch_rdata, 16'hFFFF);
    fetch_addr = 12'hD00; #1;
    chk("R9", "viol upper fetch", fetch_viol, 0);
    chk("R9", "upper data", fetch_rdata, 16'h1234);
    // R4: request while busy starts nothing
    send('hF80, 'hD00, 1);
    chk("R4", "no halt from blocked request", cpu_halt, 0);
    // R8: clear while busy ignored
    rww_clr_cmd = 1'b1; @(negedge clk); rww_clr_cmd = 1'b0;
    chk("R8", "clear while busy", rww_busy, 1);
    wait_done();
    chk("R7", "rww sticky after done", rww_busy, 1);
    chk("R4", "ready after done", req_ready, 1);
    rww_clr_cmd = 1'b1; @(negedge clk); rww_clr_cmd = 1'b0;
    chk("R8", "clear when idle", rww_busy, 0);
    fetch_addr = 12'h020; #1;
    chk("R9", "viol after clear", fetch_viol, 0);
    chk("R9", "data after clear", fetch_rdata, 16'h1234);

    // R2/R3/R6: largest boot section, erase a boot page
    boot_sz_cfg = 2'd0;
    send('hBFF, 'hF90, 1);
    chk("R2", "busy below 0xC00", busy, 0);
    send('hC00, 'hF90, 1);
    chk("R3", "boot page target accepted", busy, 1);
    chk("R6", "halt for upper target", cpu_halt, 1);
    chk("R6", "rww untouched", rww_busy, 0);
    wait_done();
    chk("R6", "halt released", cpu_halt, 0);
    @(negedge clk);

    // Collision: clear in last busy cycle, then in done cycle
    boot_sz_cfg = 2'd1;
    send('hE00, 'h300, 0);
    repeat (WRITE_LEN - 1) @(negedge clk);
    chk("R4", "last busy cycle", busy, 1);
    rww_clr_cmd = 1'b1;
    @(negedge clk);
    chk("R5", "done after last cycle", prog_done, 1);
    chk("R8", "clear in last busy cycle", rww_busy, 1);
    @(negedge clk);
    rww_clr_cmd = 1'b0;
    chk("R8", "clear in done cycle", rww_busy, 0);

    // R8: clear and lower-region acceptance on the same edge
    rww_clr_cmd = 1'b1;
    send('hE00, 'h400, 1);
    rww_clr_cmd = 1'b0;
    chk("R8", "set wins over clear", rww_busy, 1);
    chk("R4", "erase started", busy, 1);
    wait_done();
    rww_clr_cmd = 1'b1; @(negedge clk); rww_clr_cmd = 1'b0;
    chk("R8", "final clear", rww_busy, 0);

    repeat (3) @(negedge clk);
    chk("R4", "scoreboard drained", sb_q.size(), 0);
    summary();
    $finish;
  end
endmodule